// File: doc/BRIEF.md
# Pipelined Packed Subword Multiplier

This block multiplies 16-bit signed subwords taken from two 64-bit packed operands. A select input chooses one of two alternate lane sets. The even set is lanes 0 and 2, and the odd set is lanes 1 and 3. Lane 0 occupies bits 15:0 and lane 3 occupies bits 63:48. For each selected pair, the block forms the full 32-bit two's-complement product. The two products are packed into the 64-bit result: the product from the lower lane goes in bits 31:0 and the product from the upper lane goes in bits 63:32.

The unit is a three-stage pipeline that accepts one operation every clock. A destination tag and a valid flag travel in their own registers beside the data, so a writeback stage can route each result to its destination register. An input whose valid flag is low, for example a squashed or predicated-off instruction, moves through as a bubble. The reset input is asynchronous and active low. Inside the block, reset is released synchronously through a two-flop chain.

Top module: `pmul_packed_mul`

## Requirements
- R1: While `rst_n` is low, and for as long as a reset clears operations already in flight, `res_valid` is 0. After reset, no result appears until a valid operation has gone through the pipeline.
- R2: An operation sampled at a rising edge with `in_valid` high appears on the outputs with `res_valid` high after the second rising edge that follows (three-cycle latency).
- R3: With `sel_odd`=0 (even), result bits 31:0 hold lane0(a)*lane0(b) and bits 63:32 hold lane2(a)*lane2(b).
- R4: With `sel_odd`=1 (odd), result bits 31:0 hold lane1(a)*lane1(b) and bits 63:32 hold lane3(a)*lane3(b).
- R5: Lanes are signed two's-complement and products are exact 32-bit values, for example 0x8000*0x8000 = 0x40000000 and 0xFFFF*0x0001 = 0xFFFFFFFF.
- R6: Operations may be issued on consecutive cycles. Each one produces its own result on consecutive cycles, in issue order.
- R7: `res_dest` equals the `in_dest` value presented with the same operation.
- R8: An input with `in_valid`=0 produces `res_valid`=0 three cycles later and does not disturb neighbouring valid results.
- R9: The contents of the lanes that are not selected have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| sel_odd | input | 1 | 0 selects lanes 0 and 2, 1 selects lanes 1 and 3 |
| in_valid | input | 1 | Operation present this cycle |
| in_dest | input | 5 | Destination register tag |
| res | output | 64 | Two packed 32-bit products |
| res_dest | output | 5 | Tag of the result |
| res_valid | output | 1 | Result present this cycle |

## Verification
The bench builds the block with its default parameters: 16-bit lanes, two lane pairs and a 5-bit tag. These values put the most negative lane value, 0x8000, and the full 32-register tag range within reach of directed stimulus. Every cycle, a three-deep expectation pipe in the bench predicts the output. That prediction lets back-to-back streams, interleaved bubbles and a reset that lands on operations in flight all be compared on each clock edge.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic {PICK_EVEN = 1'b0, PICK_ODD = 1'b1} pick_e;
  localparam int unsigned PMUL_STAGES = 3;
endpackage

// File: rtl/pmul_rst_sync.sv
module pmul_rst_sync #(
  parameter int unsigned SYNC_FLOPS = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [SYNC_FLOPS-1:0] chain_d, chain_q;

  always_comb chain_d = {chain_q[SYNC_FLOPS-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[SYNC_FLOPS-1];
endmodule

// File: rtl/pmul_lane_pick.sv
module pmul_lane_pick
  import pmul_pkg::*;
#(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned PAIRS  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  pick_e                         pick,
  input  logic [2*PAIRS*LANE_W-1:0]     a,
  input  logic [2*PAIRS*LANE_W-1:0]     b,
  output logic [PAIRS-1:0][LANE_W-1:0]  a_q,
  output logic [PAIRS-1:0][LANE_W-1:0]  b_q
);
  logic [PAIRS-1:0][LANE_W-1:0] a_d, b_d;

  // Lane 2k+pick of each operand feeds product slot k.
  always_comb begin
    for (int k = 0; k < PAIRS; k++) begin
      a_d[k] = a[(2*k + int'(pick))*LANE_W +: LANE_W];
      b_d[k] = b[(2*k + int'(pick))*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_chk
    // R3 / R4: the captured lane matches the chosen lane of the input
    a_r4_lane_pick: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (a_q[k] == (($past(pick) == PICK_ODD) ?
                         $past(a[(2*k+1)*LANE_W +: LANE_W]) :
                         $past(a[(2*k)*LANE_W +: LANE_W]))));
    a_r3_lane_pick_b: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (b_q[k] == (($past(pick) == PICK_ODD) ?
                         $past(b[(2*k+1)*LANE_W +: LANE_W]) :
                         $past(b[(2*k)*LANE_W +: LANE_W]))));
  end
endmodule

// File: rtl/pmul_prod_pack.sv
module pmul_prod_pack #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned PAIRS  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en_mul,
  input  logic                           en_out,
  input  logic [PAIRS-1:0][LANE_W-1:0]   a_q,
  input  logic [PAIRS-1:0][LANE_W-1:0]   b_q,
  output logic [2*PAIRS*LANE_W-1:0]      res_q
);
  localparam int unsigned PROD_W = 2 * LANE_W;
  localparam int unsigned WORD_W = PAIRS * PROD_W;

  logic [PAIRS-1:0][PROD_W-1:0] prod_d, prod_q;
  logic [WORD_W-1:0]            res_d;

  always_comb begin
    for (int k = 0; k < PAIRS; k++) begin
      prod_d[k] = PROD_W'($signed(a_q[k])) * PROD_W'($signed(b_q[k]));
    end
  end

  always_comb res_d = prod_q;  // slot k lands at bits [k*PROD_W +: PROD_W]

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      res_q  <= '0;
    end else begin
      if (en_mul) prod_q <= prod_d;
      if (en_out) res_q  <= res_d;
    end
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_chk
    // R5: product sign follows operand signs when neither lane is zero
    a_r5_prod_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mul && (a_q[k] != '0) && (b_q[k] != '0)) |=>
        (prod_q[k][PROD_W-1] == ($past(a_q[k][LANE_W-1]) ^ $past(b_q[k][LANE_W-1]))));
    // R5: a zero lane yields a zero product
    a_r5_prod_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mul && ((a_q[k] == '0) || (b_q[k] == '0))) |=> (prod_q[k] == '0));
  end
endmodule

// File: rtl/pmul_tag_pipe.sv
module pmul_tag_pipe #(
  parameter int unsigned TAG_W = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [TAG_W-1:0] in_tag,
  output logic [DEPTH-1:0] v_stage,
  output logic [TAG_W-1:0] out_tag
);
  logic [DEPTH-1:0]            v_d, v_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_d, tag_q;

  always_comb begin
    v_d[0]   = in_v;
    tag_d[0] = in_v ? in_tag : tag_q[0];
    for (int i = 1; i < DEPTH; i++) begin
      v_d[i]   = v_q[i-1];
      tag_d[i] = v_q[i-1] ? tag_q[i-1] : tag_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      tag_q <= '0;
    end else begin
      v_q   <= v_d;
      tag_q <= tag_d;
    end
  end

  assign v_stage = v_q;
  assign out_tag = tag_q[DEPTH-1];

  for (genvar i = 1; i < DEPTH; i++) begin : g_chk
    a_r2_valid_walk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[i-1] |=> v_q[i]);
    a_r8_bubble_walk: assert property (@(posedge clk) disable iff (!rst_n)
      !v_q[i-1] |=> !v_q[i]);
    a_r7_tag_walk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[i-1] |=> (tag_q[i] == $past(tag_q[i-1])));
  end
endmodule

// File: rtl/pmul_packed_mul.sv
module pmul_packed_mul
  import pmul_pkg::*;
#(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned PAIRS  = 2,
  parameter int unsigned TAG_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*PAIRS*LANE_W-1:0]  op_a,
  input  logic [2*PAIRS*LANE_W-1:0]  op_b,
  input  logic                       sel_odd,
  input  logic                       in_valid,
  input  logic [TAG_W-1:0]           in_dest,
  output logic [2*PAIRS*LANE_W-1:0]  res,
  output logic [TAG_W-1:0]           res_dest,
  output logic                       res_valid
);
  logic                         srst_n;
  logic [PMUL_STAGES-1:0]       v_stage;
  logic [PAIRS-1:0][LANE_W-1:0] a_lane, b_lane;

  pmul_rst_sync #(.SYNC_FLOPS(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  pmul_tag_pipe #(.TAG_W(TAG_W), .DEPTH(PMUL_STAGES)) u_tag (
    .clk(clk), .rst_n(srst_n), .in_v(in_valid), .in_tag(in_dest),
    .v_stage(v_stage), .out_tag(res_dest)
  );

  pmul_lane_pick #(.LANE_W(LANE_W), .PAIRS(PAIRS)) u_pick (
    .clk(clk), .rst_n(srst_n), .en(in_valid), .pick(pick_e'(sel_odd)),
    .a(op_a), .b(op_b), .a_q(a_lane), .b_q(b_lane)
  );

  pmul_prod_pack #(.LANE_W(LANE_W), .PAIRS(PAIRS)) u_prod (
    .clk(clk), .rst_n(srst_n), .en_mul(v_stage[0]), .en_out(v_stage[1]),
    .a_q(a_lane), .b_q(b_lane), .res_q(res)
  );

  assign res_valid = v_stage[PMUL_STAGES-1];

  // R1: no result leaves the block while the synchronised reset is active
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    (srst_n === 1'b0) |-> !res_valid);
endmodule

// File: tb/pmul_packed_mul_tb.sv
module pmul_packed_mul_tb;
  logic        clk;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic        sel_odd, in_valid;
  logic [4:0]  in_dest;
  logic [63:0] res;
  logic [4:0]  res_dest;
  logic        res_valid;

  int total = 0;
  int bad   = 0;
  bit chk_on = 0;
  bit done   = 0;

  // expectation pipe: nx -> s0 -> s1 (s1 compared at each falling edge)
  logic        nx_v, s0_v, s1_v;
  logic [63:0] nx_r, s0_r, s1_r;
  logic [4:0]  nx_d, s0_d, s1_d;
  string       nx_q, s0_q, s1_q;

  pmul_packed_mul u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sel_odd(sel_odd),
    .in_valid(in_valid), .in_dest(in_dest), .res(res), .res_dest(res_dest),
    .res_valid(res_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic odd);
    logic [63:0] r;
    logic signed [31:0] pa, pb;
    int idx;
    r = '0;
    for (int k = 0; k < 2; k++) begin
      idx = 2*k + (odd ? 1 : 0);
      pa = {{16{a[idx*16+15]}}, a[idx*16 +: 16]};
      pb = {{16{b[idx*16+15]}}, b[idx*16 +: 16]};
      r[k*32 +: 32] = pa * pb;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(res_valid === s1_v, s1_q, "res_valid", 64'(res_valid), 64'(s1_v));
      if (s1_v) begin
        check(res === s1_r, s1_q, "res", res, s1_r);
        check(res_dest === s1_d, s1_q, "res_dest", 64'(res_dest), 64'(s1_d));
      end
    end
    s1_v = s0_v; s1_r = s0_r; s1_d = s0_d; s1_q = s0_q;
    s0_v = nx_v; s0_r = nx_r; s0_d = nx_d; s0_q = nx_q;
    nx_v = 1'b0;
  end

  task automatic op(input logic [63:0] a, input logic [63:0] b, input logic odd,
                    input logic [4:0] d, input logic v, input string req);
    @(negedge clk); #1;
    op_a = a; op_b = b; sel_odd = odd; in_dest = d; in_valid = v;
    nx_v = v && rst_n; nx_r = model(a, b, odd); nx_d = d; nx_q = req;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) op(64'hDEAD_BEEF_0BAD_F00D, 64'h1234_5678_9ABC_DEF0, 1'b0, 5'd0, 1'b0, req);
  endtask

  task automatic t_reset_state;
    idle(4, "R1");
  endtask

  task automatic t_even;  // R3
    op(64'h0004_0003_0002_0001, 64'h0010_0020_0030_0040, 1'b0, 5'd1, 1'b1, "R3");
    op(64'h1111_2222_3333_0100, 64'h0000_0200_0000_0300, 1'b0, 5'd2, 1'b1, "R3");
    op(64'h0000_7000_0000_0123, 64'hFFFF_0002_FFFF_0456, 1'b0, 5'd3, 1'b1, "R3");
    idle(3, "R3");
  endtask

  task automatic t_odd;  // R4
    op(64'h0004_0003_0002_0001, 64'h0010_0020_0030_0040, 1'b1, 5'd4, 1'b1, "R4");
    op(64'h0100_2222_0200_0100, 64'h0300_0200_0005_0300, 1'b1, 5'd5, 1'b1, "R4");
    op(64'hFFFE_0000_0009_0000, 64'h0003_0000_FFF9_0000, 1'b1, 5'd6, 1'b1, "R4");
    idle(3, "R4");
  endtask

  task automatic t_signed;  // R5
    op(64'h0000_8000_0000_8000, 64'h0000_8000_0000_0001, 1'b0, 5'd7, 1'b1, "R5");
    op(64'hFFFF_0000_7FFF_0000, 64'h0001_0000_8000_0000, 1'b1, 5'd8, 1'b1, "R5");
    op(64'h0000_7FFF_0000_FFFF, 64'h0000_7FFF_0000_FFFF, 1'b0, 5'd9, 1'b1, "R5");
    idle(3, "R5");
  endtask

  task automatic t_stream;  // R6, R7
    for (int i = 0; i < 32; i++) begin
      op({16'(i*977+3), 16'(i*31-7), 16'(i*4099), 16'(i+1)},
         {16'(i*13+5), 16'(i*503), 16'(16'h8000 - i), 16'(i*7-100)},
         1'(i % 2), 5'(31 - i), 1'b1, (i % 2) ? "R6" : "R7");
    end
    idle(3, "R6");
  endtask

  task automatic t_bubbles;  // R8
    for (int i = 0; i < 12; i++) begin
      op({16'(i*41), 16'(i*3+9), 16'(i*123), 16'(-i)},
         {16'(i*57+1), 16'(i-5), 16'(i*11), 16'(i*99)},
         1'(i % 3 == 0), 5'(i + 10), 1'((i % 3) != 1), "R8");
    end
    idle(3, "R8");
  endtask

  task automatic t_unselected;  // R9
    for (int i = 0; i < 4; i++) begin
      op({16'(i*1000+1), 16'h0025, 16'(-i*777), 16'hFF00},
         {16'(i*333), 16'hFFF3, 16'(i*5555), 16'h0042}, 1'b0, 5'd20, 1'b1, "R9");
      op({16'h0007, 16'(i*2222+9), 16'h0100, 16'(i*4321)},
         {16'hFFFE, 16'(-i*111), 16'h0300, 16'(i*17)}, 1'b1, 5'd21, 1'b1, "R9");
    end
    idle(3, "R9");
  endtask

  task automatic t_midreset;  // R1
    op(64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, 1'b0, 5'd11, 1'b1, "R1");
    op(64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, 1'b1, 5'd12, 1'b1, "R1");
    @(negedge clk); #2;
    rst_n = 1'b0;
    nx_v = 1'b0; s0_v = 1'b0; s1_v = 1'b0;
    nx_q = "R1"; s0_q = "R1"; s1_q = "R1";
    in_valid = 1'b0;
    idle(3, "R1");
    rst_n = 1'b1;
    idle(4, "R1");
    op(64'h0000_0003_0000_0002, 64'h0000_0005_0000_0007, 1'b0, 5'd13, 1'b1, "R2");
    idle(3, "R2");
  endtask

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; sel_odd = 1'b0; in_valid = 1'b0; in_dest = '0;
    nx_v = 1'b0; s0_v = 1'b0; s1_v = 1'b0;
    nx_r = '0; s0_r = '0; s1_r = '0; nx_d = '0; s0_d = '0; s1_d = '0;
    nx_q = "R1"; s0_q = "R1"; s1_q = "R1";
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    t_reset_state;
    rst_n = 1'b1;
    idle(4, "R1");
    t_even;
    t_odd;
    t_signed;
    t_stream;
    t_bubbles;
    t_unselected;
    t_midreset;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule